// File: doc/BRIEF.md
# Interleaved Multithread Issue Scheduler

This block is the issue stage of a scalar controller that runs four hardware threads interleaved cycle by cycle. Each thread has its own small in-order instruction buffer, filled by an upstream fetch stage through a per-thread push strobe. Every cycle the scheduler picks at most one thread whose buffer has an instruction and that is not waiting on a long-latency operation. It picks in rotating order, starting from the thread after the last one that issued.

An issued instruction goes one of two ways. If it names a vector register, it is written, tagged with its thread number, into an internal queue that feeds the SIMD engine. Otherwise it appears, with the same tag, on a registered scalar output. Issuing a long-latency operation takes the issuing thread out of the rotation. The thread returns when an external completion event names it.

Top module: `mt_issue_sched`

## Requirements
- R1: After reset, `sc_valid` and `vq_valid` are 0 and every bit of `buf_full` is 0.
- R2: Each thread's instructions issue in the order they were pushed. A thread buffer holds 4 entries, and `buf_full[t]` is 1 while it holds 4. A push to a full buffer is dropped.
- R3: At most one instruction issues per cycle, across the scalar output and the SIMD queue together.
- R4: Selection is round-robin over the eligible threads. The search starts at the thread after the one that last issued, and thread 0 is first after reset. With all four threads loaded, the issue order is 0,1,2,3,0,1,...
- R5: Instruction bit 31 is the vector-operand flag and bits 30:28 are the operation kind (1 multiply, 2 divide, 3 load, 4 reduction). A scalar multiply, divide or load, or a vector reduction, blocks its thread, and a blocked thread issues nothing.
- R6: `done_valid` with `done_tid` equal to a blocked thread makes that thread eligible again from the next cycle.
- R7: An instruction with bit 31 clear appears on `sc_instr`, with `sc_valid` high for one cycle and `sc_tid` holding the issuing thread.
- R8: A thread whose next instruction is a vector one is skipped while the SIMD queue (4 entries) is full. It keeps that instruction, and the other threads continue to issue.
- R9: When no thread is eligible, nothing is issued.
- R10: An instruction pushed into an empty buffer of an unblocked thread, with no competing thread, appears on the scalar output one clock after the push edge.
- R11: An instruction with bit 31 set enters the SIMD queue tagged with its thread. `vq_valid` shows the queue is not empty, and `vq_pop` removes the head, so entries leave in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 4 | Per-thread write strobe into the thread buffer |
| push_instr | input | 128 | Per-thread instruction, thread t in bits 32t+31:32t |
| buf_full | output | 4 | Thread buffer holds 4 entries |
| done_valid | input | 1 | Completion of a long-latency operation |
| done_tid | input | 2 | Thread whose operation completed |
| sc_valid | output | 1 | Scalar instruction issued |
| sc_instr | output | 32 | Scalar instruction |
| sc_tid | output | 2 | Thread tag of the scalar instruction |
| vq_valid | output | 1 | SIMD queue not empty |
| vq_instr | output | 32 | Instruction at the SIMD queue head |
| vq_tid | output | 2 | Thread tag at the SIMD queue head |
| vq_pop | input | 1 | Remove the SIMD queue head |

## Verification
The bound assertions check the per-cycle rules on every cycle:
- one pick at a time;
- no pick of a blocked thread;
- no write into a full SIMD queue;
- wake-up one cycle after completion;
- blocking after a long-latency issue;
- the round-robin successor being taken when it is eligible.

Only the bench scenarios can show the following:
- per-thread ordering of the issued stream;
- the exact rotation order;
- dropping of pushes to a full buffer;
- a stalled vector instruction being held and then delivered intact once the queue drains.

// File: rtl/mis_pkg.sv
package mis_pkg;
  localparam int unsigned IW = 32;

  typedef enum logic [2:0] {
    OPK_PLAIN  = 3'd0,
    OPK_MUL    = 3'd1,
    OPK_DIV    = 3'd2,
    OPK_LOAD   = 3'd3,
    OPK_REDUCE = 3'd4
  } op_kind_e;

  // top: bits 31:28 of an instruction
  function automatic logic uses_vector(input logic [3:0] top);
    return top[3];
  endfunction

  function automatic logic blocks_thread(input logic [3:0] top);
    logic [2:0] k;
    k = top[2:0];
    if (top[3]) return (k == OPK_REDUCE);
    return (k == OPK_MUL) || (k == OPK_DIV) || (k == OPK_LOAD);
  endfunction
endpackage

// File: rtl/mis_tbuf.sv
module mis_tbuf #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = mem[rp_q];
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (rd_ok) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/mis_rr_pick.sv
module mis_rr_pick #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  elig,
  input  logic [TW-1:0] start,
  output logic          any,
  output logic [TW-1:0] sel,
  output logic [N-1:0]  sel_oh
);
  always_comb begin
    any    = 1'b0;
    sel    = start;
    sel_oh = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (int'(start) + i) % N;
      if (!any && elig[j]) begin
        any       = 1'b1;
        sel       = TW'(j);
        sel_oh[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
  import mis_pkg::*;
#(
  parameter  int NTHR       = 4,
  parameter  int TBUF_DEPTH = 4,
  parameter  int VQ_DEPTH   = 4,
  localparam int TW         = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NTHR-1:0]    push_valid,
  input  logic [NTHR*IW-1:0] push_instr,
  output logic [NTHR-1:0]    buf_full,
  input  logic               done_valid,
  input  logic [TW-1:0]      done_tid,
  output logic               sc_valid,
  output logic [IW-1:0]      sc_instr,
  output logic [TW-1:0]      sc_tid,
  output logic               vq_valid,
  output logic [IW-1:0]      vq_instr,
  output logic [TW-1:0]      vq_tid,
  input  logic               vq_pop
);
  logic [IW-1:0]   head [NTHR];
  logic [NTHR-1:0] empty;
  logic [NTHR-1:0] elig;
  logic [NTHR-1:0] active_q, active_d;
  logic [NTHR-1:0] pick_oh;
  logic [TW-1:0]   ptr_q, ptr_d, pick_tid;
  logic            issue, issue_vec, issue_blk, vq_wr, vq_full, vq_empty;
  logic [IW-1:0]   issue_instr;
  logic            sc_valid_d;

  // per-thread buffers and eligibility
  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    mis_tbuf #(.W(IW), .DEPTH(TBUF_DEPTH)) u_tbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (push_valid[g]),
      .wr_data(push_instr[g*IW +: IW]),
      .rd_en  (issue && (pick_tid == TW'(g))),
      .head   (head[g]),
      .empty  (empty[g]),
      .full   (buf_full[g])
    );
    assign elig[g] = !empty[g] && active_q[g] &&
                     !(uses_vector(head[g][IW-1 -: 4]) && vq_full);
  end

  mis_rr_pick #(.N(NTHR), .TW(TW)) u_pick (
    .elig  (elig),
    .start (ptr_q),
    .any   (issue),
    .sel   (pick_tid),
    .sel_oh(pick_oh)
  );

  assign issue_instr = head[pick_tid];
  assign issue_vec   = uses_vector(issue_instr[IW-1 -: 4]);
  assign issue_blk   = blocks_thread(issue_instr[IW-1 -: 4]);
  assign vq_wr       = issue && issue_vec;
  assign sc_valid_d  = issue && !issue_vec;

  // next state: rotation pointer and per-thread run state
  always_comb begin
    ptr_d = ptr_q;
    if (issue) ptr_d = (pick_tid == TW'(NTHR - 1)) ? '0 : pick_tid + 1'b1;
    active_d = active_q;
    for (int t = 0; t < NTHR; t++) begin
      if (issue && issue_blk && pick_oh[t]) active_d[t] = 1'b0;
      else if (done_valid && (done_tid == TW'(t))) active_d[t] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      active_q <= '1;
      sc_valid <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      active_q <= active_d;
      sc_valid <= sc_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_instr <= '0;
      sc_tid   <= '0;
    end else if (sc_valid_d) begin
      sc_instr <= issue_instr;
      sc_tid   <= pick_tid;
    end
  end

  // SIMD instruction queue, entry = {tid, instr}
  mis_tbuf #(.W(IW + TW), .DEPTH(VQ_DEPTH)) u_vq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (vq_wr),
    .wr_data({pick_tid, issue_instr}),
    .rd_en  (vq_pop),
    .head   ({vq_tid, vq_instr}),
    .empty  (vq_empty),
    .full   (vq_full)
  );
  assign vq_valid = !vq_empty;
endmodule

// File: rtl/mis_sva.sv
module mis_sva
  import mis_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int TW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTHR-1:0] elig,
  input logic [NTHR-1:0] active_q,
  input logic [NTHR-1:0] pick_oh,
  input logic            issue,
  input logic [TW-1:0]   pick_tid,
  input logic [IW-1:0]   issue_instr,
  input logic            vq_wr,
  input logic            vq_full,
  input logic            done_valid,
  input logic [TW-1:0]   done_tid,
  input logic            sc_valid,
  input logic [IW-1:0]   sc_instr
);
  p_single_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh) && (issue == (pick_oh != '0)));

  p_no_blocked_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> active_q[pick_tid]);

  p_block_after_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && blocks_thread(issue_instr[IW-1 -: 4])) |=> !active_q[$past(pick_tid)]);

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !active_q[done_tid]) |=> active_q[$past(done_tid)]);

  p_scalar_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |-> !uses_vector(sc_instr[IW-1 -: 4]));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vq_wr |-> !vq_full);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !issue);

  p_rotation_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (!elig[TW'($past(pick_tid) + 1'b1)] ||
               (issue && pick_tid == TW'($past(pick_tid) + 1'b1))));
endmodule

bind mt_issue_sched mis_sva #(.NTHR(NTHR), .TW(TW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .elig       (elig),
  .active_q   (active_q),
  .pick_oh    (pick_oh),
  .issue      (issue),
  .pick_tid   (pick_tid),
  .issue_instr(issue_instr),
  .vq_wr      (vq_wr),
  .vq_full    (vq_full),
  .done_valid (done_valid),
  .done_tid   (done_tid),
  .sc_valid   (sc_valid),
  .sc_instr   (sc_instr)
);

// File: tb/test_mt_issue_sched.sv
module test_mt_issue_sched;
  localparam int NT = 4;
  localparam int TBD = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    push_valid;
  logic [127:0]  push_instr;
  logic [3:0]    buf_full;
  logic          done_valid;
  logic [1:0]    done_tid;
  logic          sc_valid, vq_valid, vq_pop;
  logic [31:0]   sc_instr, vq_instr;
  logic [1:0]    sc_tid, vq_tid;

  always #2 clk = ~clk;

  mt_issue_sched i_mt_issue_sched (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_instr(push_instr),
    .buf_full(buf_full), .done_valid(done_valid), .done_tid(done_tid),
    .sc_valid(sc_valid), .sc_instr(sc_instr), .sc_tid(sc_tid),
    .vq_valid(vq_valid), .vq_instr(vq_instr), .vq_tid(vq_tid), .vq_pop(vq_pop));

  int total = 0;
  int bad = 0;
  logic [31:0] exp_sc [NT][$];
  logic [33:0] exp_vq [$];
  int          order_log [$];
  int          sc_cnt [NT];
  int          vq_pops = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; push_valid = '0; push_instr = '0; done_valid = 1'b0;
    done_tid = '0; vq_pop = 1'b0;
    tick(); tick();
    for (int t = 0; t < NT; t++) begin exp_sc[t].delete(); sc_cnt[t] = 0; end
    exp_vq.delete(); order_log.delete(); vq_pops = 0;
    rst_n = 1'b1;
    tick();
  endtask

  // driver: push one instruction per masked thread in the same cycle
  task automatic push(input logic [3:0] mask, input logic [31:0] base, input bit expect_ok);
    push_valid = mask;
    for (int t = 0; t < NT; t++) begin
      push_instr[t*32 +: 32] = base | 32'(t);
      if (mask[t] && expect_ok) begin
        if (base[31]) exp_vq.push_back({2'(t), base | 32'(t)});
        else exp_sc[t].push_back(base | 32'(t));
      end
    end
    tick();
    push_valid = '0;
  endtask

  task automatic done(input int t);
    done_valid = 1'b1; done_tid = 2'(t);
    tick();
    done_valid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (sc_valid) begin
        order_log.push_back(int'(sc_tid));
        sc_cnt[sc_tid]++;
        if (exp_sc[sc_tid].size() == 0)
          chk(1'b0, "R7 unexpected scalar", {30'd0, sc_tid, sc_instr}, 64'd0);
        else begin
          logic [31:0] e;
          e = exp_sc[sc_tid].pop_front();
          chk(sc_instr == e, "R2/R7 scalar stream", {32'd0, sc_instr}, {32'd0, e});
        end
      end
      if (vq_valid && vq_pop) begin
        vq_pops++;
        if (exp_vq.size() == 0)
          chk(1'b0, "R11 unexpected vector", {30'd0, vq_tid, vq_instr}, 64'd0);
        else begin
          logic [33:0] e;
          e = exp_vq.pop_front();
          chk({vq_tid, vq_instr} == e, "R11 vector stream", {30'd0, vq_tid, vq_instr}, {30'd0, e});
        end
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk(sc_valid == 1'b0, "R1 sc_valid", 64'(sc_valid), 0);
    chk(vq_valid == 1'b0, "R1 vq_valid", 64'(vq_valid), 0);
    chk(buf_full == 4'h0, "R1 buf_full", 64'(buf_full), 0);

    // R10 latency
    push(4'b0100, 32'h0000_1200, 1'b1);
    @(negedge clk);
    chk(sc_valid == 1'b0, "R10 not yet", 64'(sc_valid), 0);
    @(negedge clk);
    chk(sc_valid == 1'b1 && sc_tid == 2'd2, "R10 one clock after push", {sc_valid, sc_tid}, {1'b1, 2'd2});
    wait_cyc(3);

    // R4 rotation from reset
    do_reset();
    push(4'hF, 32'h0000_0A00, 1'b1);
    push(4'hF, 32'h0000_0B00, 1'b1);
    wait_cyc(12);
    begin
      int exp_o [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
      chk(order_log.size() == 8, "R4 count", 64'(order_log.size()), 8);
      for (int i = 0; i < 8 && i < order_log.size(); i++)
        chk(order_log[i] == exp_o[i], "R4 order", 64'(order_log[i]), 64'(exp_o[i]));
    end

    // R5/R6 blocked thread skipped, then wakes
    do_reset();
    push(4'b0010, 32'h3000_0100, 1'b1);  // scalar load on thread 1
    wait_cyc(3);
    order_log.delete();
    push(4'hF, 32'h0000_0C00, 1'b1);
    push(4'hF, 32'h0000_0D00, 1'b1);
    wait_cyc(10);
    begin
      int exp_o [6] = '{2, 3, 0, 2, 3, 0};
      chk(order_log.size() == 6, "R5 blocked thread skipped count", 64'(order_log.size()), 6);
      for (int i = 0; i < 6 && i < order_log.size(); i++)
        chk(order_log[i] == exp_o[i], "R5 skip order", 64'(order_log[i]), 64'(exp_o[i]));
    end
    done(1);
    wait_cyc(5);
    chk(order_log.size() == 8, "R6 woken thread issues", 64'(order_log.size()), 8);
    if (order_log.size() == 8)
      chk(order_log[6] == 1 && order_log[7] == 1, "R6 woken tid", 64'(order_log[7]), 1);

    // R5 vector reduction blocks, vector multiply does not
    do_reset();
    vq_pop = 1'b1;
    push(4'b0001, 32'hC000_0000, 1'b1);
    push(4'b0001, 32'h0000_0E00, 1'b1);
    wait_cyc(6);
    chk(sc_cnt[0] == 0, "R5 reduction blocks thread 0", 64'(sc_cnt[0]), 0);
    done(0);
    wait_cyc(4);
    chk(sc_cnt[0] == 1, "R6 thread 0 after completion", 64'(sc_cnt[0]), 1);
    push(4'b1000, 32'h9000_0000, 1'b1);
    push(4'b1000, 32'h0000_0F00, 1'b1);
    wait_cyc(5);
    chk(sc_cnt[3] == 1, "R5 vector multiply does not block", 64'(sc_cnt[3]), 1);
    chk(vq_pops == 2, "R11 vector pops", 64'(vq_pops), 2);

    // R2 full buffer drops push
    do_reset();
    push(4'b0100, 32'h2000_0000, 1'b1);  // scalar divide blocks thread 2
    wait_cyc(3);
    for (int i = 0; i < TBD; i++) push(4'b0100, 32'h0000_1000 | 32'(i << 8), 1'b1);
    @(negedge clk);
    chk(buf_full[2] == 1'b1, "R2 full flag", 64'(buf_full), 64'h4);
    tick();
    push(4'b0100, 32'h0000_7700, 1'b0);   // dropped
    done(2);
    wait_cyc(10);
    chk(sc_cnt[2] == 1 + TBD, "R2 only buffered entries issue", 64'(sc_cnt[2]), 64'(1 + TBD));
    chk(buf_full[2] == 1'b0, "R2 buffer drained", 64'(buf_full[2]), 0);

    // R8 SIMD queue full: thread held, others continue
    do_reset();
    for (int i = 0; i < 5; i++) push(4'b0001, 32'h8000_0000 | 32'(i << 8), 1'b1);
    wait_cyc(3);
    chk(vq_valid == 1'b1, "R11 queue not empty", 64'(vq_valid), 1);
    push(4'b0100, 32'h0000_5500, 1'b1);
    wait_cyc(3);
    chk(sc_cnt[2] == 1, "R8 other thread issues while queue full", 64'(sc_cnt[2]), 1);
    chk(vq_pops == 0, "R8 nothing popped yet", 64'(vq_pops), 0);
    vq_pop = 1'b1;
    wait_cyc(10);
    chk(vq_pops == 5, "R8 held vector delivered", 64'(vq_pops), 5);
    chk(vq_valid == 1'b0, "R11 queue empty", 64'(vq_valid), 0);

    // R9 idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(sc_valid == 1'b0, "R9 no issue when idle", 64'(sc_valid), 0);
    end

    // R3 each issue counted once: totals match pushes
    chk(exp_vq.size() == 0, "R3 vector queue drained", 64'(exp_vq.size()), 0);
    for (int t = 0; t < NT; t++)
      chk(exp_sc[t].size() == 0, "R2 all scalar issued", 64'(exp_sc[t].size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule